// File: doc/BRIEF.md
# Synchronous FIFO Bridge Emulator

This block stands in for the bridge chip at the far end of a 16-bit synchronous FIFO bus. With it in place, an FPGA-side bus master can be exercised in simulation or on a board without the real device. Both directions share one bus clock, and each moves at most one 16-bit word per clock.

In the bridge-to-master direction the emulator offers words from an internal source, whose word sequence can be computed. A low `rxf_n` flag tells the master that data is available. After a burst of selectable length the flag goes high for a gap. The gap length is either programmed or drawn from a pseudo-random generator. In the master-to-bridge direction the emulator captures words into a buffer of 4096 bytes. It raises `txe_n` while that buffer is full. The buffer empties toward a notional host at one word every `drain_div` clocks, and each word that leaves appears on `drain_valid`/`drain_data`.

Counters of words sent, words received and elapsed clocks let a bench work out the effective throughput against the 200 MB/s peak. The bus is split into separate in and out directions, and a qualifier marks when the bridge drives read data.

Top module: `fifo_bridge_emu`

## Requirements
- R1: After reset, `rxf_n` and `txe_n` are both low, `drain_valid` is low, and `words_sent`, `words_rcvd` and `cycles` are zero.
- R2: `rd_valid` is high exactly when `oe_n` and `rd_n` are both low. While it is high, `rd_be` is 2'b11 and `rd_data` shows the current source word. While it is low, `rd_data` is zero and `rd_be` is 2'b00.
- R3: A source word is consumed only on a clock edge where `rxf_n` and `rd_n` are both low. The k-th consumed word (k counted from 0) equals the low 16 bits of k XOR `SRC_SEED` (default 16'h5A3C).
- R4: A burst holds the following number of words: 256 when `burst_sel` is 0, 512 when it is 1, and 1024 when it is 2 or 3. After the last word of a burst has been consumed, `rxf_n` goes high.
- R5: When `gap_rand` is 0, `rxf_n` stays high after a burst for exactly max(`gap_cfg`, 4) clocks.
- R6: When `gap_rand` is 1, each gap lasts between 4 and 511 clocks inclusive.
- R7: A word is captured only on an edge where `txe_n` and `wr_n` are both low. `wr_be` bit 0 enables bits 7:0 and bit 1 enables bits 15:8. A disabled byte lane is stored as 8'h00.
- R8: `txe_n` is high while the buffer holds 2048 words. It is low whenever at least one word of space is free. Writes made while it is high are ignored.
- R9: With `drain_div` = N > 0, one word leaves the buffer every N clocks while it is non-empty, in the order captured, and shows on `drain_data` with `drain_valid`. With N = 0, nothing drains.
- R10: `words_sent` and `words_rcvd` count consumed and captured words. `cycles` rises by one on every clock out of reset.
- R11: A read strobe given while `rxf_n` is high consumes nothing. The word offered next is unchanged, and `words_sent` does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_sel | input | 2 | Burst length select for bridge-to-master data |
| gap_rand | input | 1 | 1: pseudo-random gap, 0: gap from gap_cfg |
| gap_cfg | input | 9 | Programmed gap length in clocks (minimum 4) |
| drain_div | input | 8 | Clocks per drained word; 0 pauses draining |
| rxf_n | output | 1 | Low when read data is available |
| oe_n | input | 1 | Master output-enable, active low |
| rd_n | input | 1 | Master read strobe, active low |
| rd_valid | output | 1 | Bridge is driving rd_data and rd_be |
| rd_data | output | 16 | Read data word |
| rd_be | output | 2 | Read byte enables |
| txe_n | output | 1 | Low when the buffer can accept a word |
| wr_n | input | 1 | Master write strobe, active low |
| wr_data | input | 16 | Write data word |
| wr_be | input | 2 | Write byte enables |
| drain_valid | output | 1 | A buffered word leaves this cycle |
| drain_data | output | 16 | Word leaving the buffer |
| words_sent | output | 32 | Words consumed by the master |
| words_rcvd | output | 32 | Words captured from the master |
| cycles | output | 32 | Clocks since reset |

## Verification
The assertions assume that the master changes its strobes only between edges. They also assume that `drain_div` and `burst_sel` are steady values rather than glitches. Under those assumptions, each strobe the bridge accepts corresponds to exactly one step of a counter. The bench changes `burst_sel` and `gap_cfg` only at burst boundaries, while it holds `rd_n` high. It also keeps write traffic in the drain phase sparser than the drain rate, so the buffer is bound to empty. Random strobes, data and byte enables cover both legal and ignored transfers, and both flags are driven through their busy states.

// File: rtl/emu_pkg.sv
package emu_pkg;

    localparam int BURST_CNT_W = 11;
    localparam int BURST_BASE  = 256;

    typedef enum logic {
        SRC_RUN = 1'b0,
        SRC_GAP = 1'b1
    } src_state_e;

    // words per burst: base doubled per select step, capped at two steps
    function automatic logic [BURST_CNT_W-1:0] burst_words(input logic [1:0] sel);
        logic [1:0] step;
        step = (sel > 2'd2) ? 2'd2 : sel;
        return BURST_CNT_W'(BURST_BASE) << step;
    endfunction

endpackage

// File: rtl/emu_src_burst.sv
module emu_src_burst
    import emu_pkg::*;
#(
    parameter int                 DATA_W    = 16,
    parameter int                 GAP_W     = 9,
    parameter int                 MIN_GAP   = 4,
    parameter logic [DATA_W-1:0]  SRC_SEED  = 16'h5A3C,
    parameter logic [GAP_W-1:0]   LFSR_SEED = 9'h1A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        burst_sel,
    input  logic              gap_rand,
    input  logic [GAP_W-1:0]  gap_cfg,
    input  logic              rd_n,
    output logic              rxf_n,
    output logic              take,
    output logic [DATA_W-1:0] src_word
);

    localparam logic [GAP_W-1:0] GAP_FLOOR = GAP_W'(MIN_GAP);

    typedef struct packed {
        src_state_e             state;
        logic [DATA_W-1:0]      idx;
        logic [BURST_CNT_W-1:0] bcnt;
        logic [GAP_W-1:0]       gap;
        logic [GAP_W-1:0]       lfsr;
    } src_t;

    src_t s_d, s_q;

    function automatic logic [GAP_W-1:0] floor_gap(input logic [GAP_W-1:0] v);
        return (v < GAP_FLOOR) ? GAP_FLOOR : v;
    endfunction

    always_comb begin
        s_d  = s_q;
        take = (s_q.state == SRC_RUN) && !rd_n;
        case (s_q.state)
            SRC_RUN: begin
                if (take) begin
                    s_d.idx = s_q.idx + 1'b1;
                    if ((s_q.bcnt + 1'b1) >= burst_words(burst_sel)) begin
                        s_d.bcnt  = '0;
                        s_d.state = SRC_GAP;
                        s_d.gap   = gap_rand ? floor_gap(s_q.lfsr) : floor_gap(gap_cfg);
                        s_d.lfsr  = {s_q.lfsr[GAP_W-2:0], s_q.lfsr[GAP_W-1] ^ s_q.lfsr[4]};
                    end else begin
                        s_d.bcnt = s_q.bcnt + 1'b1;
                    end
                end
            end
            SRC_GAP: begin
                if (s_q.gap <= GAP_W'(1)) begin
                    s_d.state = SRC_RUN;
                end else begin
                    s_d.gap = s_q.gap - 1'b1;
                end
            end
            default: s_d.state = SRC_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state <= SRC_RUN;
            s_q.idx   <= '0;
            s_q.bcnt  <= '0;
            s_q.gap   <= '0;
            s_q.lfsr  <= LFSR_SEED;
        end else begin
            s_q <= s_d;
        end
    end

    assign rxf_n    = (s_q.state == SRC_GAP);
    assign src_word = s_q.idx ^ SRC_SEED;

endmodule

// File: rtl/emu_sink_buf.sv
module emu_sink_buf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2048,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DIV_W-1:0]  drain_div,
    output logic              txe_n,
    output logic              put,
    output logic              drain_valid,
    output logic [DATA_W-1:0] drain_data
);

    localparam int AW    = $clog2(DEPTH);
    localparam int LANES = DATA_W / 8;
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]     wp;
        logic [AW-1:0]     rp;
        logic [AW:0]       fill;
        logic [DIV_W-1:0]  div;
        logic              dvalid;
        logic [DATA_W-1:0] ddata;
    } sink_t;

    sink_t s_d, s_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] masked;
    logic              tick, pop;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*8 +: 8] = wr_be[g] ? wr_data[g*8 +: 8] : 8'h00;
    end

    always_comb begin
        s_d  = s_q;
        put  = !wr_n && (s_q.fill != FULL_LVL);
        tick = (drain_div != '0) && (s_q.div >= (drain_div - 1'b1));
        pop  = tick && (s_q.fill != '0);

        if (drain_div == '0 || tick) s_d.div = '0;
        else                         s_d.div = s_q.div + 1'b1;

        if (put) s_d.wp = s_q.wp + 1'b1;
        if (pop) s_d.rp = s_q.rp + 1'b1;

        case ({put, pop})
            2'b10:   s_d.fill = s_q.fill + 1'b1;
            2'b01:   s_d.fill = s_q.fill - 1'b1;
            default: s_d.fill = s_q.fill;
        endcase

        s_d.dvalid = pop;
        s_d.ddata  = pop ? mem[s_q.rp] : s_q.ddata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (put) mem[s_q.wp] <= masked;
    end

    assign txe_n       = (s_q.fill == FULL_LVL);
    assign drain_valid = s_q.dvalid;
    assign drain_data  = s_q.ddata;

endmodule

// File: rtl/fifo_bridge_emu.sv
module fifo_bridge_emu #(
    parameter int                 DATA_W    = 16,
    parameter int                 BUF_BYTES = 4096,
    parameter int                 GAP_W     = 9,
    parameter int                 MIN_GAP   = 4,
    parameter int                 DIV_W     = 8,
    parameter int                 CNT_W     = 32,
    parameter logic [DATA_W-1:0]  SRC_SEED  = 16'h5A3C,
    parameter logic [GAP_W-1:0]   LFSR_SEED = 9'h1A5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          burst_sel,
    input  logic                gap_rand,
    input  logic [GAP_W-1:0]    gap_cfg,
    input  logic [DIV_W-1:0]    drain_div,
    output logic                rxf_n,
    input  logic                oe_n,
    input  logic                rd_n,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W/8-1:0] rd_be,
    output logic                txe_n,
    input  logic                wr_n,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_be,
    output logic                drain_valid,
    output logic [DATA_W-1:0]   drain_data,
    output logic [CNT_W-1:0]    words_sent,
    output logic [CNT_W-1:0]    words_rcvd,
    output logic [CNT_W-1:0]    cycles
);

    localparam int BE_W  = DATA_W / 8;
    localparam int DEPTH = BUF_BYTES / BE_W;

    typedef struct packed {
        logic [CNT_W-1:0] sent;
        logic [CNT_W-1:0] rcvd;
        logic [CNT_W-1:0] clks;
    } cnt_t;

    cnt_t c_d, c_q;
    logic              take, put;
    logic [DATA_W-1:0] src_word;

    emu_src_burst #(
        .DATA_W   (DATA_W),
        .GAP_W    (GAP_W),
        .MIN_GAP  (MIN_GAP),
        .SRC_SEED (SRC_SEED),
        .LFSR_SEED(LFSR_SEED)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .burst_sel(burst_sel),
        .gap_rand (gap_rand),
        .gap_cfg  (gap_cfg),
        .rd_n     (rd_n),
        .rxf_n    (rxf_n),
        .take     (take),
        .src_word (src_word)
    );

    emu_sink_buf #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .DIV_W (DIV_W)
    ) u_sink (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_n       (wr_n),
        .wr_data    (wr_data),
        .wr_be      (wr_be),
        .drain_div  (drain_div),
        .txe_n      (txe_n),
        .put        (put),
        .drain_valid(drain_valid),
        .drain_data (drain_data)
    );

    always_comb begin
        c_d      = c_q;
        c_d.clks = c_q.clks + 1'b1;
        if (take) c_d.sent = c_q.sent + 1'b1;
        if (put)  c_d.rcvd = c_q.rcvd + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rd_valid   = !oe_n && !rd_n;
    assign rd_data    = rd_valid ? src_word : '0;
    assign rd_be      = rd_valid ? '1 : '0;
    assign words_sent = c_q.sent;
    assign words_rcvd = c_q.rcvd;
    assign cycles     = c_q.clks;

endmodule

// File: rtl/emu_bridge_chk.sv
module emu_bridge_chk #(
    parameter int CNT_W = 32,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rxf_n,
    input logic             txe_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             drain_valid,
    input logic [DIV_W-1:0] drain_div,
    input logic [CNT_W-1:0] words_sent,
    input logic [CNT_W-1:0] words_rcvd,
    input logic [CNT_W-1:0] cycles
);

    assert_take_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxf_n && !rd_n) |=> (words_sent == $past(words_sent) + 1'b1));

    assert_no_take_in_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_n |=> $stable(words_sent));

    assert_capture_counts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!txe_n && !wr_n) |=> (words_rcvd == $past(words_rcvd) + 1'b1));

    assert_no_capture_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        txe_n |=> $stable(words_rcvd));

    assert_drain_paused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_div == '0) |=> !drain_valid);

    assert_cycle_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cycles == $past(cycles) + 1'b1));

endmodule

bind fifo_bridge_emu emu_bridge_chk #(
    .CNT_W(CNT_W),
    .DIV_W(DIV_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxf_n      (rxf_n),
    .txe_n      (txe_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .drain_valid(drain_valid),
    .drain_div  (drain_div),
    .words_sent (words_sent),
    .words_rcvd (words_rcvd),
    .cycles     (cycles)
);

// File: tb/sim_fifo_bridge_emu.sv
module sim_fifo_bridge_emu;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] SRC_SEED   = 16'h5A3C;
    localparam int          DEPTH      = 2048;
    localparam int          WDOG_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  burst_sel = 2'd0;
    logic        gap_rand = 1'b0;
    logic [8:0]  gap_cfg = 9'd10;
    logic [7:0]  drain_div = 8'd0;
    logic        oe_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be = 2'b11;
    logic        rxf_n, txe_n, rd_valid, drain_valid;
    logic [15:0] rd_data, drain_data;
    logic [1:0]  rd_be;
    logic [31:0] words_sent, words_rcvd, cycles;

    fifo_bridge_emu #(.SRC_SEED(SRC_SEED)) u0 (
        .clk(clk), .rst_n(rst_n), .burst_sel(burst_sel), .gap_rand(gap_rand),
        .gap_cfg(gap_cfg), .drain_div(drain_div), .rxf_n(rxf_n), .oe_n(oe_n),
        .rd_n(rd_n), .rd_valid(rd_valid), .rd_data(rd_data), .rd_be(rd_be),
        .txe_n(txe_n), .wr_n(wr_n), .wr_data(wr_data), .wr_be(wr_be),
        .drain_valid(drain_valid), .drain_data(drain_data),
        .words_sent(words_sent), .words_rcvd(words_rcvd), .cycles(cycles)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    int k     = 0;
    int rcv   = 0;
    logic [15:0] q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int idx);
        return 16'(idx) ^ SRC_SEED;
    endfunction

    function automatic int exp_burst(input int sel);
        return (sel == 0) ? 256 : (sel == 1) ? 512 : 1024;
    endfunction

    function automatic int exp_gap(input int cfg);
        return (cfg < 4) ? 4 : cfg;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [15:0] d, input logic [1:0] be);
        return {be[1] ? d[15:8] : 8'h00, be[0] ? d[7:0] : 8'h00};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WDOG_LIMIT) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WDOG_LIMIT);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic run_reads(input int sel, input int nb, input bit rnd_gap,
                             input int cfg, input bit rnd_rd);
        int inb  = 0;
        int gapc = 0;
        int done = 0;
        burst_sel = 2'(sel);
        gap_rand  = rnd_gap;
        gap_cfg   = 9'(cfg);
        while (done < nb) begin
            @(negedge clk);
            if (rxf_n) begin
                gapc++;
            end else if (gapc > 0) begin
                check(inb == exp_burst(sel), "R4", "burst length", inb, exp_burst(sel));
                if (rnd_gap) check(gapc >= 4 && gapc <= 511, "R6", "random gap", gapc, 4);
                else         check(gapc == exp_gap(cfg), "R5", "fixed gap", gapc, exp_gap(cfg));
                done++;
                inb  = 0;
                gapc = 0;
            end
            if (done < nb) begin
                rd_n = rnd_rd ? ($urandom % 3 == 0) : 1'b0;
                oe_n = rnd_rd ? ($urandom % 4 == 0) : 1'b0;
                #1;
                check(rd_valid == (!oe_n && !rd_n), "R2", "rd_valid", rd_valid, !oe_n && !rd_n);
                if (!oe_n && !rd_n) begin
                    // R3 word order, R11 word unchanged across gap strobes
                    check(rd_data == exp_word(k), "R3", "source word", rd_data, exp_word(k));
                    check(rd_be == 2'b11, "R2", "rd_be driven", rd_be, 2'b11);
                end else begin
                    check(rd_data == 16'h0 && rd_be == 2'b00, "R2", "bus released",
                          {rd_be, rd_data}, 0);
                end
                if (!rxf_n && !rd_n) begin
                    k++;
                    inb++;
                end
            end
        end
        rd_n = 1'b1;
        oe_n = 1'b1;
        check(words_sent == 32'(k), "R11", "words_sent after gaps", words_sent, k);
    endtask

    initial begin
        int   c0;
        int   last;
        bit   contig;
        bit   first;
        int   seen;
        void'($urandom(32'd4242));

        // R1 reset state
        repeat (3) @(negedge clk);
        check(rxf_n == 1'b0, "R1", "rxf_n in reset", rxf_n, 0);
        check(txe_n == 1'b0, "R1", "txe_n in reset", txe_n, 0);
        check(drain_valid == 1'b0, "R1", "drain_valid in reset", drain_valid, 0);
        check(words_sent == 0 && words_rcvd == 0 && cycles == 0, "R1", "counters in reset",
              words_sent | words_rcvd | cycles, 0);
        check(rd_valid == 1'b0, "R1", "rd_valid idle", rd_valid, 0);
        rst_n = 1'b1;

        // R10 cycle counter
        @(negedge clk);
        c0 = int'(cycles);
        repeat (40) @(negedge clk);
        check(int'(cycles) - c0 == 40, "R10", "cycle count step", int'(cycles) - c0, 40);

        // read direction: directed bursts, then random strobes and gaps
        run_reads(0, 2, 1'b0, 10, 1'b0);
        run_reads(1, 1, 1'b0, 2, 1'b0);
        run_reads(3, 1, 1'b0, 300, 1'b1);
        run_reads(0, 2, 1'b0, 4 + int'($urandom % 200), 1'b1);
        run_reads(2, 3, 1'b1, 0, 1'b1);

        // write direction: fill with draining paused
        drain_div = 8'd0;
        seen = 0;
        while (rcv < DEPTH) begin
            @(negedge clk);
            if (drain_valid) seen++;
            wr_n    = ($urandom % 4 == 0);
            wr_data = 16'($urandom);
            wr_be   = ($urandom % 2 == 1) ? 2'b11 : 2'($urandom);
            if (!txe_n && !wr_n) begin
                q.push_back(lane_mask(wr_data, wr_be));
                rcv++;
            end
        end
        @(negedge clk);
        wr_n = 1'b1;
        check(txe_n == 1'b1, "R8", "txe_n when full", txe_n, 1);
        check(words_rcvd == 32'(DEPTH), "R10", "words_rcvd at full", words_rcvd, DEPTH);
        repeat (16) begin
            @(negedge clk);
            if (drain_valid) seen++;
            wr_n    = 1'b0;
            wr_data = 16'($urandom);
        end
        @(negedge clk);
        wr_n = 1'b1;
        check(words_rcvd == 32'(DEPTH), "R8", "writes ignored when full", words_rcvd, DEPTH);
        check(txe_n == 1'b1, "R8", "txe_n stays high", txe_n, 1);
        check(seen == 0, "R9", "no drain while paused", seen, 0);

        // drain at one word per 3 clocks with sparse writes
        drain_div = 8'd3;
        last   = -1;
        contig = 1'b0;
        first  = 1'b1;
        while (q.size() > 0) begin
            @(negedge clk);
            if (drain_valid) begin
                // R7 lane masking and R9 order both show in the drained word
                check(drain_data == q[0], "R9", "drain order and R7 lanes", drain_data, q[0]);
                void'(q.pop_front());
                if (first) check(txe_n == 1'b0, "R8", "space after first drain", txe_n, 0);
                first = 1'b0;
                if (last >= 0 && contig)
                    check(cyc - last == 3, "R9", "drain spacing", cyc - last, 3);
                contig = (q.size() > 0);
                last   = cyc;
            end
            wr_n    = ($urandom % 8 != 0);
            wr_data = 16'($urandom);
            wr_be   = 2'($urandom);
            if (!txe_n && !wr_n) begin
                q.push_back(lane_mask(wr_data, wr_be));
                rcv++;
            end
        end
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        check(words_rcvd == 32'(rcv), "R10", "words_rcvd total", words_rcvd, rcv);
        check(words_sent == 32'(k), "R10", "words_sent total", words_sent, k);
        check(txe_n == 1'b0, "R8", "txe_n low when empty", txe_n, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule